// File: doc/BRIEF.md
# Floating-Point Subtract Special-Case Resolver

This block settles the result of DEST minus SRC for single-precision operands in every case that needs no real arithmetic: when either operand is zero, infinite or NaN, or when the two operands are bitwise identical. It classifies both operands and applies the sign-of-zero rule for the selected rounding mode. It raises an invalid-operation flag where one is due, and presents a registered result one cycle after the request. The operation is always DEST minus SRC and the operands are never reordered.

When both operands are nonzero finite values that differ, the block produces no value. It raises a "needs arithmetic" flag and forwards both operands, with SRC already in single-precision form, to a separate adder datapath. A mode flag tells the block to read the SRC port as a signed 32-bit integer. The block converts that integer to single precision under the current rounding mode, and an integer zero is taken as +0.

Top module: `fp_sub_resolve`

## Requirements
- R1: `out_valid` is 0 out of reset and, for every request, equals `in_valid` delayed by exactly one clock. Result fields are captured only on cycles where `in_valid` is 1.
- R2: If either operand is a NaN, the result is DEST with bit 22 (the quiet bit) forced to 1 when DEST is a NaN, and otherwise SRC with bit 22 forced to 1. `invalid` is 1 exactly when a NaN operand has bit 22 clear (a signaling NaN).
- R3: Two infinities of the same sign set `invalid` and give the default NaN 0xFFC00000.
- R4: If only DEST is infinite, or both are infinite with opposite signs, the result is DEST. If only SRC is infinite, the result is SRC with bit 31 inverted.
- R5: Two zeros of the same sign, or two bitwise-equal nonzero finite operands, give 0x00000000. Under the round-toward-negative-infinity mode they give 0x80000000 instead. `rm` encoding: 00 nearest-even, 01 toward −∞, 10 toward +∞, 11 toward zero.
- R6: Two zeros of opposite sign give DEST in every rounding mode (+0 − −0 = +0, −0 − +0 = −0).
- R7: A nonzero finite DEST minus a zero SRC gives DEST unchanged. A zero DEST minus a nonzero finite SRC gives SRC with bit 31 inverted. Denormals count as nonzero finite.
- R8: When `int_src` is 1, `src_op` is a two's-complement integer. It is converted to single precision, rounded as `rm` selects, before any rule applies. Integer 0 becomes +0.
- R9: Two nonzero finite operands that are not bitwise equal set `need_arith` and clear `result` and `invalid`. `arith_dest` carries DEST and `arith_src` carries the (converted) SRC.
- R10: `invalid` and `need_arith` are never both 1. `invalid` is 0 in every case not named in R2 or R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe; operands sampled on this cycle |
| int_src | input | 1 | 1: `src_op` is a signed integer |
| rm | input | 2 | Rounding mode (00 nearest, 01 down, 10 up, 11 toward zero) |
| dest_op | input | 32 | Minuend, single precision |
| src_op | input | 32 | Subtrahend, single precision or signed integer |
| out_valid | output | 1 | Registered outputs valid |
| result | output | 32 | Final difference when resolved here |
| invalid | output | 1 | Invalid-operation exception |
| need_arith | output | 1 | Operands must go to the adder datapath |
| arith_dest | output | 32 | DEST forwarded to the adder |
| arith_src | output | 32 | SRC forwarded to the adder, converted if integer |

## Verification
The assertions assume that `in_valid`, `int_src` and `rm` are known at every rising edge after reset, and that the operands are known whenever `in_valid` is 1. The bench drives every input from reset onward and changes inputs only on falling edges. The stimulus covers every pairing of a set of floating-point values with each rounding mode, in both source modes. The set spans signed zeros, denormals, normals, extremes, infinities and quiet and signaling NaNs of both signs. The integer values sit on rounding boundaries above 2^24 and at both ends of the 32-bit range.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_FINITE,
    CL_INF,
    CL_QNAN,
    CL_SNAN
  } opclass_e;

  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_DOWN = 2'b01;
  localparam logic [1:0] RM_UP   = 2'b10;
  localparam logic [1:0] RM_TRNC = 2'b11;

endpackage

// File: rtl/fsr_classify.sv
module fsr_classify
  import fsr_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op,
  output opclass_e     cls
);

  logic [EXP_W-1:0] expf;
  logic [MAN_W-1:0] manf;

  always_comb begin
    expf = op[W-2 -: EXP_W];
    manf = op[MAN_W-1:0];
    if (&expf) begin
      if (manf == '0)          cls = CL_INF;
      else if (manf[MAN_W-1])  cls = CL_QNAN;
      else                     cls = CL_SNAN;
    end else if (expf == '0 && manf == '0) begin
      cls = CL_ZERO;
    end else begin
      cls = CL_FINITE;
    end
  end

endmodule

// File: rtl/fsr_int_to_fp.sv
module fsr_int_to_fp
  import fsr_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int LZ_W = $clog2(INT_W) + 1,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
  input  logic [INT_W-1:0] ival,
  input  logic [1:0]       rm,
  output logic [W-1:0]     fval
);

  logic             neg, guard, sticky, inexact, up;
  logic [INT_W-1:0] mag, norm;
  logic [LZ_W-1:0]  lz;
  logic [MAN_W:0]   keep;
  logic [MAN_W+1:0] sum;
  logic [EXP_W-1:0] expv;

  always_comb begin
    neg = ival[INT_W-1];
    mag = neg ? (~ival + 1'b1) : ival;
    lz  = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lz = LZ_W'(INT_W - 1 - i);
    end
    norm    = mag << lz;
    keep    = norm[INT_W-1 -: MAN_W+1];
    guard   = norm[INT_W-MAN_W-2];
    sticky  = |norm[INT_W-MAN_W-3:0];
    inexact = guard | sticky;
    case (rm)
      RM_NEAR: up = guard & (sticky | keep[0]);
      RM_DOWN: up = neg & inexact;
      RM_UP:   up = ~neg & inexact;
      default: up = 1'b0;
    endcase
    sum  = {1'b0, keep} + (MAN_W+2)'(up);
    expv = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz) + EXP_W'(sum[MAN_W+1]);
    if (mag == '0) fval = '0;
    else fval = {neg, expv, sum[MAN_W+1] ? {MAN_W{1'b0}} : sum[MAN_W-1:0]};
  end

endmodule

// File: rtl/fsr_decide.sv
module fsr_decide
  import fsr_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] dest,
  input  logic [W-1:0] src,
  input  opclass_e     dcls,
  input  opclass_e     scls,
  input  logic [1:0]   rm,
  output logic [W-1:0] res,
  output logic         inv,
  output logic         need
);

  localparam logic [W-1:0] QUIET_BIT = W'(1) << (MAN_W - 1);
  localparam logic [W-1:0] SIGN_BIT  = W'(1) << (W - 1);
  localparam logic [W-1:0] DFLT_NAN  = {1'b1, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic dnan, snan, same_sign;
  logic [W-1:0] zero_res;

  always_comb begin
    dnan      = (dcls == CL_QNAN) || (dcls == CL_SNAN);
    snan      = (scls == CL_QNAN) || (scls == CL_SNAN);
    same_sign = dest[W-1] == src[W-1];
    zero_res  = (rm == RM_DOWN) ? SIGN_BIT : '0;
    res  = '0;
    inv  = 1'b0;
    need = 1'b0;
    if (dnan || snan) begin
      inv = (dcls == CL_SNAN) || (scls == CL_SNAN);
      res = dnan ? (dest | QUIET_BIT) : (src | QUIET_BIT);
    end else if (dcls == CL_INF && scls == CL_INF) begin
      if (same_sign) begin
        inv = 1'b1;
        res = DFLT_NAN;
      end else begin
        res = dest;
      end
    end else if (dcls == CL_INF) begin
      res = dest;
    end else if (scls == CL_INF) begin
      res = src ^ SIGN_BIT;
    end else if (dcls == CL_ZERO && scls == CL_ZERO) begin
      res = same_sign ? zero_res : dest;
    end else if (scls == CL_ZERO) begin
      res = dest;
    end else if (dcls == CL_ZERO) begin
      res = src ^ SIGN_BIT;
    end else if (dest == src) begin
      res = zero_res;
    end else begin
      need = 1'b1;
    end
  end

endmodule

// File: rtl/fp_sub_resolve.sv
module fp_sub_resolve
  import fsr_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         int_src,
  input  logic [1:0]   rm,
  input  logic [W-1:0] dest_op,
  input  logic [W-1:0] src_op,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         invalid,
  output logic         need_arith,
  output logic [W-1:0] arith_dest,
  output logic [W-1:0] arith_src
);

  logic [W-1:0] src_conv, src_fp;
  logic [W-1:0] ops [2];
  opclass_e     cls [2];

  logic [W-1:0] res_d;
  logic         inv_d, need_d;

  fsr_int_to_fp #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(W)) u_conv (
    .ival (src_op),
    .rm   (rm),
    .fval (src_conv)
  );

  always_comb begin
    src_fp = int_src ? src_conv : src_op;
    ops[0] = dest_op;
    ops[1] = src_fp;
  end

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fsr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (ops[g]),
      .cls (cls[g])
    );
  end

  fsr_decide #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_decide (
    .dest (dest_op),
    .src  (src_fp),
    .dcls (cls[0]),
    .scls (cls[1]),
    .rm   (rm),
    .res  (res_d),
    .inv  (inv_d),
    .need (need_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      invalid    <= 1'b0;
      need_arith <= 1'b0;
      arith_dest <= '0;
      arith_src  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= res_d;
        invalid    <= inv_d;
        need_arith <= need_d;
        arith_dest <= dest_op;
        arith_src  <= src_fp;
      end
    end
  end

  // R1: output strobe follows the request by one clock
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10: flags never both high
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(invalid && need_arith));
  // R3 / R2: an exception always yields a quiet NaN
  a_r3_invalid_gives_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid) |-> ((&result[W-2 -: EXP_W]) && result[MAN_W-1]));
  // R9: forwarding leaves the result cleared and the operands forwarded
  a_r9_arith_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && need_arith) |-> (result == '0 && arith_dest == $past(dest_op)));
  // R8: integer conversion never yields an infinity or NaN
  a_r8_conv_finite: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && int_src) |-> !(&src_conv[W-2 -: EXP_W]));

endmodule

// File: tb/test_fp_sub_resolve.sv
module test_fp_sub_resolve;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        int_src = 1'b0;
  logic [1:0]  rm = 2'b00;
  logic [31:0] dest_op = '0;
  logic [31:0] src_op = '0;
  logic        out_valid, invalid, need_arith;
  logic [31:0] result, arith_dest, arith_src;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_sub_resolve i_fp_sub_resolve (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .int_src(int_src), .rm(rm),
    .dest_op(dest_op), .src_op(src_op), .out_valid(out_valid), .result(result),
    .invalid(invalid), .need_arith(need_arith), .arith_dest(arith_dest),
    .arith_src(arith_src)
  );

  function automatic logic [31:0] fval(int k);
    case (k)
      0: return 32'h00000000;  1: return 32'h80000000;
      2: return 32'h00000001;  3: return 32'h80000001;
      4: return 32'h3F800000;  5: return 32'hBF800000;
      6: return 32'h3FC00000;  7: return 32'h3F800001;
      8: return 32'h7F7FFFFF;  9: return 32'hFF7FFFFF;
      10: return 32'h7F800000; 11: return 32'hFF800000;
      12: return 32'h7FC00000; 13: return 32'hFFC12345;
      14: return 32'h7F800001; 15: return 32'hFFA00000;
      default: return 32'h40490FDB;
    endcase
  endfunction

  function automatic logic [31:0] ival(int k);
    case (k)
      0: return 32'd0;         1: return 32'd1;
      2: return 32'hFFFFFFFF;  3: return 32'd7;
      4: return -32'sd7;       5: return 32'd16777216;
      6: return 32'd16777217;  7: return 32'd16777219;
      8: return -32'sd16777217; 9: return 32'h7FFFFFFF;
      10: return 32'h80000000; default: return 32'd33554435;
    endcase
  endfunction

  // R8 reference: integer to single precision by remainder comparison
  function automatic logic [31:0] to_sp(logic [31:0] v, logic [1:0] m);
    longint mag, q, r, half;
    int p;
    bit neg, up;
    neg = v[31];
    mag = neg ? (64'sd4294967296 - longint'(v)) : longint'(v);
    if (mag == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) p = i;
    if (p <= 23) begin
      q = mag << (23 - p);
      r = 0;
      half = 1;
    end else begin
      q = mag >> (p - 23);
      r = mag - (q << (p - 23));
      half = longint'(1) << (p - 24);
    end
    case (m)
      2'b00: up = (r > half) || (r == half && q[0]);
      2'b01: up = neg && r != 0;
      2'b10: up = !neg && r != 0;
      default: up = 1'b0;
    endcase
    if (up) q = q + 1;
    if (q == 64'd16777216) begin
      q = 64'd8388608;
      p = p + 1;
    end
    return {neg, 8'(127 + p), q[22:0]};
  endfunction

  function automatic void model(input logic [31:0] d, input logic [31:0] s,
                                input logic [1:0] m, output logic [31:0] res,
                                output bit inv, output bit na, output string tag);
    bit dn, sn, dsn, ssn, di, si, dz, sz;
    dn  = d[30:23] == 8'hFF && d[22:0] != 0;
    sn  = s[30:23] == 8'hFF && s[22:0] != 0;
    dsn = dn && !d[22];
    ssn = sn && !s[22];
    di  = d[30:0] == 31'h7F800000;
    si  = s[30:0] == 31'h7F800000;
    dz  = d[30:0] == 0;
    sz  = s[30:0] == 0;
    res = 32'h0; inv = 0; na = 0;
    if (dn || sn) begin
      tag = "R2"; inv = dsn || ssn;
      res = dn ? (d | 32'h00400000) : (s | 32'h00400000);
    end else if (di && si) begin
      if (d[31] == s[31]) begin tag = "R3"; inv = 1; res = 32'hFFC00000; end
      else begin tag = "R4"; res = d; end
    end else if (di) begin tag = "R4"; res = d;
    end else if (si) begin tag = "R4"; res = {~s[31], s[30:0]};
    end else if (dz && sz) begin
      if (d[31] == s[31]) begin tag = "R5"; res = (m == 2'b01) ? 32'h80000000 : 32'h0; end
      else begin tag = "R6"; res = d; end
    end else if (sz) begin tag = "R7"; res = d;
    end else if (dz) begin tag = "R7"; res = {~s[31], s[30:0]};
    end else if (d == s) begin tag = "R5"; res = (m == 2'b01) ? 32'h80000000 : 32'h0;
    end else begin tag = "R9"; na = 1; end
  endfunction

  task automatic run_one(logic [31:0] d, logic [31:0] s, bit im, logic [1:0] m);
    logic [31:0] sf, er;
    bit ei, en;
    string tag;
    sf = im ? to_sp(s, m) : s;
    model(d, sf, m, er, ei, en, tag);
    if (im) tag = {"R8/", tag};
    @(negedge clk);
    dest_op = d; src_op = s; int_src = im; rm = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!out_valid || result !== er || invalid !== ei || need_arith !== en ||
        (en && (arith_dest !== d || arith_src !== sf))) begin
      fails++;
      $display("FAIL %s d=%h s=%h int=%0d rm=%0d: got v=%0d res=%h inv=%0d na=%0d fwd=%h/%h, exp res=%h inv=%0d na=%0d fwd=%h/%h (R10 flags)",
               tag, d, s, im, m, out_valid, result, invalid, need_arith, arith_dest,
               arith_src, er, ei, en, d, sf);
    end
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 out_valid after idle cycle: got %0d exp 0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || invalid !== 1'b0 || need_arith !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: got v=%0d res=%h inv=%0d na=%0d exp 0/0/0/0",
               out_valid, result, invalid, need_arith);
    end
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 17; a++)
        for (int b = 0; b < 17; b++)
          run_one(fval(a), fval(b), 1'b0, 2'(m));
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 17; a++)
        for (int b = 0; b < 12; b++)
          run_one(fval(a), ival(b), 1'b1, 2'(m));
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule